// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block is the digital half of a processor supply supervisor. Analog comparators and the power switch stay outside it and report through two level flags: supply below threshold and running on the backup battery. From these flags, from a watchdog service line and from a timing source, it produces a processor reset in both polarities, a latched watchdog fault line, a low-line indication and a gated RAM chip-enable. The gating blocks writes while the supply is not trustworthy.

Time is measured in ticks. In internal-oscillator mode a tick is each pulse of a free-running system tick input. In external mode a tick is every EXT_DIV-th rising edge of an external clock. The reset pulse width and both watchdog periods are parameters in ticks or in external clocks. After every reset the watchdog first allows a long period. The first service edge then switches it to the normal period, which is short or long according to a level input. All asynchronous inputs pass through two flip-flops before use.

Top module: `psup_top`

## Requirements
- R1: Reset (reset_n_o low) is held while low_supply_i or batt_mode_i is high; once both are low it stays asserted for the reset-active time (INT_RST_TICKS ticks internal, EXT_RST_CLKS external clocks) and then releases. After rst_n it is asserted for one reset-active time.
- R2: reset_o is always the complement of reset_n_o.
- R3: A watchdog timeout asserts reset for one reset-active time; with no service the timeouts repeat, each a long period after the previous reset release.
- R4: A rising and a falling edge on wdi_i both restart the watchdog count from zero.
- R5: While wdi_float_i is high the watchdog never times out; it also does not count while supply is bad or reset is asserted.
- R6: The count restarts at reset release with the long period; after the first wdi_i edge that follows, the normal period applies.
- R7: With osc_sel_i low (external), one tick is EXT_DIV rising edges of ext_clk_i, the normal period is EXT_NORM_CLKS, the long period EXT_LONG_CLKS and the reset-active time EXT_RST_CLKS external clocks (defaults 1024, 4096, 2048, divide by 64).
- R8: With osc_sel_i high (internal), osc_in_i high makes the normal period equal to INT_LONG_TICKS and osc_in_i low makes it INT_SHORT_TICKS.
- R9: wdo_n_o goes low on a timeout and returns high on the next wdi_i edge; it is forced high while supply is bad; it is high after rst_n.
- R10: ce_out_n_o follows ce_in_n_i while supply is good and is forced high (inactive) while low_supply_i or batt_mode_i is high.
- R11: low_line_n_o is low while low_supply_i or batt_mode_i is high and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| low_supply_i | input | 1 | Supply below reset threshold |
| batt_mode_i | input | 1 | Backup battery is powering the rail |
| wdi_i | input | 1 | Watchdog service line |
| wdi_float_i | input | 1 | Service line is undriven; disables the watchdog |
| osc_sel_i | input | 1 | 1 = internal tick, 0 = external clock |
| osc_in_i | input | 1 | Internal mode: 1 = long normal period, 0 = short |
| ext_clk_i | input | 1 | External timing clock (sampled) |
| sys_tick_i | input | 1 | Internal tick pulse |
| ce_in_n_i | input | 1 | Chip-enable request, active low |
| reset_n_o | output | 1 | Processor reset, active low |
| reset_o | output | 1 | Processor reset, active high |
| wdo_n_o | output | 1 | Watchdog fault, low after a timeout |
| ce_out_n_o | output | 1 | Gated chip-enable, active low |
| low_line_n_o | output | 1 | Low when supply is bad |

## Verification
The bench builds the block with INT_RST_TICKS=6, INT_LONG_TICKS=24, INT_SHORT_TICKS=8, EXT_DIV=4 and external counts of 32, 128 and 64 clocks. It sends an internal tick every 4 cycles and toggles the external clock every 2 cycles. With these values a full long period, repeated timeout pulses, the long-to-short handover and the switch to external mode all fit in a few thousand cycles. Every width is measured in clock cycles and compared against the tick arithmetic, within a tolerance of one tick plus the synchronizer delay.

// File: rtl/psup_pkg.sv
package psup_pkg;

  typedef struct packed {
    logic low;
    logic batt;
    logic wdi;
    logic flt;
    logic osc_sel;
    logic osc_in;
    logic ext_clk;
    logic tick;
    logic ce_n;
  } psup_in_t;

  localparam int unsigned SYNC_W = $bits(psup_in_t);

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic supply_bad(logic low, logic batt);
    return low | batt;
  endfunction

  function automatic int unsigned rst_ticks(logic ext, int unsigned ext_rst,
                                            int unsigned int_rst);
    return ext ? ext_rst : int_rst;
  endfunction

  function automatic int unsigned long_ticks(logic ext, int unsigned ext_long,
                                             int unsigned int_long);
    return ext ? ext_long : int_long;
  endfunction

  function automatic int unsigned norm_ticks(logic ext, logic osc_hi,
                                             int unsigned ext_norm,
                                             int unsigned int_long,
                                             int unsigned int_short);
    if (ext) return ext_norm;
    return osc_hi ? int_long : int_short;
  endfunction

endpackage

// File: rtl/psup_sync.sv
module psup_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] stage;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= {2{RST_VAL[i]}};
      else        stage <= {stage[0], d[i]};
    end
    assign q[i] = stage[1];
  end
endmodule

// File: rtl/psup_tickgen.sv
module psup_tickgen #(
  parameter int unsigned DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_mode,
  input  logic ext_clk_s,
  input  logic sys_tick_s,
  output logic tick
);
  logic ext_prev, sys_prev;
  logic ext_rise, sys_rise, ext_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev <= 1'b0;
      sys_prev <= 1'b0;
    end else begin
      ext_prev <= ext_clk_s;
      sys_prev <= sys_tick_s;
    end
  end

  assign ext_rise = ext_clk_s & ~ext_prev;
  assign sys_rise = sys_tick_s & ~sys_prev;

  if (DIV <= 1) begin : g_nodiv
    assign ext_tick = ext_rise;
  end else begin : g_div
    localparam int unsigned PW = $clog2(DIV);
    logic [PW-1:0] pre;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pre <= '0;
      else if (!ext_mode)        pre <= '0;
      else if (ext_rise) begin
        if (pre == PW'(DIV - 1)) pre <= '0;
        else                     pre <= pre + 1'b1;
      end
    end
    assign ext_tick = ext_rise && (pre == PW'(DIV - 1));
  end

  assign tick = ext_mode ? ext_tick : sys_rise;
endmodule

// File: rtl/psup_rstgen.sv
module psup_rstgen #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bad,
  input  logic             tick,
  input  logic             wd_timeout,
  input  logic [CNT_W-1:0] rst_len,
  output logic             rst_active
);
  logic [CNT_W-1:0] cnt;
  logic             boot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      boot <= 1'b1;
    end else begin
      boot <= 1'b0;
      if (boot || bad || wd_timeout) cnt <= rst_len;
      else if (tick && cnt != '0)    cnt <= cnt - 1'b1;
    end
  end

  assign rst_active = boot | bad | (cnt != '0);
endmodule

// File: rtl/psup_wdog.sv
module psup_wdog #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wdi_s,
  input  logic             flt,
  input  logic             bad,
  input  logic             rst_active,
  input  logic [CNT_W-1:0] period_long,
  input  logic [CNT_W-1:0] period_norm,
  output logic             wd_timeout,
  output logic             wdi_edge,
  output logic             wdo_n
);
  logic             wdi_prev, first, en;
  logic [CNT_W-1:0] cnt, limit;

  assign wdi_edge   = (wdi_s ^ wdi_prev) & ~flt;
  assign en         = ~flt & ~bad & ~rst_active;
  assign limit      = first ? period_long : period_norm;
  assign wd_timeout = en & tick & ~wdi_edge & (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdi_prev <= 1'b0;
      first    <= 1'b1;
      cnt      <= '0;
      wdo_n    <= 1'b1;
    end else begin
      wdi_prev <= wdi_s;

      if (rst_active)    first <= 1'b1;
      else if (wdi_edge) first <= 1'b0;

      if (!en || wdi_edge) cnt <= '0;
      else if (tick)       cnt <= wd_timeout ? '0 : cnt + 1'b1;

      if (bad)             wdo_n <= 1'b1;
      else if (wd_timeout) wdo_n <= 1'b0;
      else if (wdi_edge)   wdo_n <= 1'b1;
    end
  end
endmodule

// File: rtl/psup_top.sv
module psup_top #(
  parameter int unsigned INT_RST_TICKS   = 200,
  parameter int unsigned INT_LONG_TICKS  = 1600,
  parameter int unsigned INT_SHORT_TICKS = 100,
  parameter int unsigned EXT_DIV         = 64,
  parameter int unsigned EXT_NORM_CLKS   = 1024,
  parameter int unsigned EXT_LONG_CLKS   = 4096,
  parameter int unsigned EXT_RST_CLKS    = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_supply_i,
  input  logic batt_mode_i,
  input  logic wdi_i,
  input  logic wdi_float_i,
  input  logic osc_sel_i,
  input  logic osc_in_i,
  input  logic ext_clk_i,
  input  logic sys_tick_i,
  input  logic ce_in_n_i,
  output logic reset_n_o,
  output logic reset_o,
  output logic wdo_n_o,
  output logic ce_out_n_o,
  output logic low_line_n_o
);
  import psup_pkg::*;

  localparam int unsigned EXT_NORM_T = EXT_NORM_CLKS / EXT_DIV;
  localparam int unsigned EXT_LONG_T = EXT_LONG_CLKS / EXT_DIV;
  localparam int unsigned EXT_RST_T  = EXT_RST_CLKS / EXT_DIV;
  localparam int unsigned MAX_T = max2(max2(max2(INT_RST_TICKS, INT_LONG_TICKS),
                                            max2(INT_SHORT_TICKS, EXT_NORM_T)),
                                       max2(EXT_LONG_T, EXT_RST_T));
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  localparam psup_in_t SYNC_RST = '{low: 1'b0, batt: 1'b0, wdi: 1'b0, flt: 1'b1,
                                    osc_sel: 1'b1, osc_in: 1'b1, ext_clk: 1'b0,
                                    tick: 1'b0, ce_n: 1'b1};

  psup_in_t         raw, s;
  logic [SYNC_W-1:0] s_vec;
  logic             sup_bad, ext_mode, tick_evt, wd_float;
  logic             rst_active, wd_timeout, wdi_edge, wdo_n;
  logic [CNT_W-1:0] rst_len, period_long, period_norm;

  assign raw = '{low: low_supply_i, batt: batt_mode_i, wdi: wdi_i, flt: wdi_float_i,
                 osc_sel: osc_sel_i, osc_in: osc_in_i, ext_clk: ext_clk_i,
                 tick: sys_tick_i, ce_n: ce_in_n_i};

  psup_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(s_vec)
  );
  assign s = psup_in_t'(s_vec);

  assign sup_bad  = supply_bad(s.low, s.batt);
  assign ext_mode = ~s.osc_sel;
  assign wd_float = s.flt;

  assign rst_len     = CNT_W'(rst_ticks(ext_mode, EXT_RST_T, INT_RST_TICKS));
  assign period_long = CNT_W'(long_ticks(ext_mode, EXT_LONG_T, INT_LONG_TICKS));
  assign period_norm = CNT_W'(norm_ticks(ext_mode, s.osc_in, EXT_NORM_T,
                                         INT_LONG_TICKS, INT_SHORT_TICKS));

  psup_tickgen #(.DIV(EXT_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .ext_clk_s(s.ext_clk),
    .sys_tick_s(s.tick), .tick(tick_evt)
  );

  psup_rstgen #(.CNT_W(CNT_W)) u_rst (
    .clk(clk), .rst_n(rst_n), .bad(sup_bad), .tick(tick_evt),
    .wd_timeout(wd_timeout), .rst_len(rst_len), .rst_active(rst_active)
  );

  psup_wdog #(.CNT_W(CNT_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .tick(tick_evt), .wdi_s(s.wdi), .flt(wd_float),
    .bad(sup_bad), .rst_active(rst_active), .period_long(period_long),
    .period_norm(period_norm), .wd_timeout(wd_timeout), .wdi_edge(wdi_edge),
    .wdo_n(wdo_n)
  );

  assign reset_n_o    = ~rst_active;
  assign reset_o      = rst_active;
  assign wdo_n_o      = wdo_n;
  assign ce_out_n_o   = sup_bad | s.ce_n;
  assign low_line_n_o = ~sup_bad;
endmodule

// File: rtl/psup_chk.sv
module psup_chk (
  input logic clk,
  input logic rst_n,
  input logic sup_bad,
  input logic wd_float,
  input logic tick_evt,
  input logic wd_timeout,
  input logic wdi_edge,
  input logic reset_n_o,
  input logic wdo_n_o,
  input logic ce_out_n_o
);
  AST_BAD_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    sup_bad |-> !reset_n_o); // R1
  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_n_o) |-> $past(tick_evt)); // R1
  AST_TIMEOUT_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    wd_timeout |=> !reset_n_o); // R3
  AST_FLOAT_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    wd_float |-> !wd_timeout); // R5
  AST_TIMEOUT_DROPS_WDO: assert property (@(posedge clk) disable iff (!rst_n)
    wd_timeout |=> !wdo_n_o); // R9
  AST_EDGE_RAISES_WDO: assert property (@(posedge clk) disable iff (!rst_n)
    wdi_edge |=> wdo_n_o); // R9
  AST_BAD_BLOCKS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    sup_bad |-> ce_out_n_o); // R10
endmodule

bind psup_top psup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sup_bad(sup_bad), .wd_float(wd_float),
  .tick_evt(tick_evt), .wd_timeout(wd_timeout), .wdi_edge(wdi_edge),
  .reset_n_o(reset_n_o), .wdo_n_o(wdo_n_o), .ce_out_n_o(ce_out_n_o)
);

// File: tb/sim_psup_top.sv
`timescale 1ns/1ps
module sim_psup_top;
  localparam int RST_T = 6, LONG_T = 24, SHORT_T = 8;
  localparam int DIV = 4, E_NORM = 32, E_LONG = 128, E_RST = 64;
  localparam int TP  = 4;          // cycles per internal tick
  localparam int ETP = 4 * DIV;    // cycles per external tick (ext clk period 4)
  localparam int TOL = 8, ETOL = 24;

  logic clk = 0, rst_n = 0;
  logic low_supply_i = 0, batt_mode_i = 0, wdi_i = 0, wdi_float_i = 1;
  logic osc_sel_i = 1, osc_in_i = 0, ext_clk_i = 0, sys_tick_i = 0, ce_in_n_i = 1;
  logic reset_n_o, reset_o, wdo_n_o, ce_out_n_o, low_line_n_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  psup_top #(.INT_RST_TICKS(RST_T), .INT_LONG_TICKS(LONG_T), .INT_SHORT_TICKS(SHORT_T),
             .EXT_DIV(DIV), .EXT_NORM_CLKS(E_NORM), .EXT_LONG_CLKS(E_LONG),
             .EXT_RST_CLKS(E_RST)) u0 (
    .clk(clk), .rst_n(rst_n), .low_supply_i(low_supply_i), .batt_mode_i(batt_mode_i),
    .wdi_i(wdi_i), .wdi_float_i(wdi_float_i), .osc_sel_i(osc_sel_i), .osc_in_i(osc_in_i),
    .ext_clk_i(ext_clk_i), .sys_tick_i(sys_tick_i), .ce_in_n_i(ce_in_n_i),
    .reset_n_o(reset_n_o), .reset_o(reset_o), .wdo_n_o(wdo_n_o),
    .ce_out_n_o(ce_out_n_o), .low_line_n_o(low_line_n_o)
  );

  initial forever begin
    repeat (3) @(negedge clk);
    sys_tick_i = 1;
    @(negedge clk);
    sys_tick_i = 0;
  end

  initial forever begin
    repeat (2) @(negedge clk);
    ext_clk_i = ~ext_clk_i;
  end

  task automatic chk_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(string req, string what, int act, int exp, int tol);
    checks++;
    if (act < exp - tol || act > exp + tol) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d+-%0d", req, what, act, exp, tol);
    end
  endtask

  task automatic wait_rn(input logic v, input int maxc, output int n);
    n = 0;
    while (reset_n_o !== v && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset_state();
    repeat (5) @(negedge clk);
    chk_eq("R1", "reset_n in reset", int'(reset_n_o), 0);
    chk_eq("R2", "reset_o in reset", int'(reset_o), 1);
    chk_eq("R9", "wdo_n in reset", int'(wdo_n_o), 1);
    rst_n = 1;
  endtask

  task automatic t_powerup();
    int n;
    wait_rn(1, 500, n);
    chk_rng("R1", "power-up reset width", n, RST_T * TP, TOL);
    chk_eq("R2", "reset_o after release", int'(reset_o), 0);
    chk_eq("R11", "low_line_n good supply", int'(low_line_n_o), 1);
  endtask

  task automatic t_float();
    int low_seen = 0;
    for (int i = 0; i < LONG_T * TP * 3; i++) begin
      @(negedge clk);
      if (reset_n_o !== 1'b1) low_seen++;
    end
    chk_eq("R5", "resets while floating", low_seen, 0);
  endtask

  task automatic t_periodic();
    int n;
    osc_in_i = 0;
    wdi_float_i = 0;
    wait_rn(0, 1000, n);
    chk_rng("R6", "first timeout uses long period", n, LONG_T * TP + 3, TOL);
    repeat (2) @(negedge clk);
    chk_eq("R9", "wdo_n after timeout", int'(wdo_n_o), 0);
    wait_rn(1, 500, n);
    chk_rng("R3", "watchdog reset width", n + 2, RST_T * TP, TOL);
    wait_rn(0, 1000, n);
    chk_rng("R3", "repeat timeout period", n, LONG_T * TP, TOL);
    wait_rn(1, 500, n);
  endtask

  task automatic t_handover();
    int n, low_seen = 0;
    repeat (12) @(negedge clk);
    wdi_i = ~wdi_i;
    repeat (4) @(negedge clk);
    chk_eq("R9", "wdo_n raised by edge", int'(wdo_n_o), 1);
    wait_rn(0, 1000, n);
    chk_rng("R6", "short period after first edge", n + 4, SHORT_T * TP + 3, TOL);
    wait_rn(1, 500, n);
    // both edge directions must restart: spacing 6 ticks < short period of 8
    for (int k = 0; k < 8; k++) begin
      wdi_i = ~wdi_i;
      for (int c = 0; c < 6 * TP; c++) begin
        @(negedge clk);
        if (reset_n_o !== 1'b1) low_seen++;
      end
    end
    chk_eq("R4", "resets while kicked on both edges", low_seen, 0);
  endtask

  task automatic t_osc_hi();
    int n;
    osc_in_i = 1;
    repeat (4) @(negedge clk);
    wdi_i = ~wdi_i;
    repeat (SHORT_T * TP + 16) @(negedge clk);
    chk_eq("R8", "no short timeout with osc_in high", int'(reset_n_o), 1);
    wait_rn(0, 1000, n);
    chk_rng("R8", "normal period equals long", n + SHORT_T * TP + 16, LONG_T * TP + 3, TOL);
    wait_rn(1, 500, n);
    osc_in_i = 0;
  endtask

  task automatic t_supply();
    int n;
    wdi_float_i = 1;
    ce_in_n_i = 0;
    repeat (4) @(negedge clk);
    chk_eq("R10", "ce follows when good", int'(ce_out_n_o), 0);
    chk_eq("R9", "wdo_n low before supply fault", int'(wdo_n_o), 0);
    low_supply_i = 1;
    repeat (4) @(negedge clk);
    chk_eq("R1", "reset on low supply", int'(reset_n_o), 0);
    chk_eq("R11", "low_line_n on low supply", int'(low_line_n_o), 0);
    chk_eq("R10", "ce forced high on low supply", int'(ce_out_n_o), 1);
    chk_eq("R9", "wdo_n forced high on low supply", int'(wdo_n_o), 1);
    ce_in_n_i = 1; repeat (4) @(negedge clk);
    ce_in_n_i = 0; repeat (4) @(negedge clk);
    chk_eq("R10", "ce still forced after toggle", int'(ce_out_n_o), 1);
    low_supply_i = 0;
    wait_rn(1, 500, n);
    chk_rng("R1", "reset width after supply recovers", n, RST_T * TP + 3, TOL);
    batt_mode_i = 1;
    repeat (4) @(negedge clk);
    chk_eq("R11", "low_line_n in battery mode", int'(low_line_n_o), 0);
    chk_eq("R1", "reset in battery mode", int'(reset_n_o), 0);
    chk_eq("R10", "ce forced in battery mode", int'(ce_out_n_o), 1);
    batt_mode_i = 0;
    wait_rn(1, 500, n);
    ce_in_n_i = 1;
  endtask

  task automatic t_ext();
    int n;
    osc_sel_i = 0;
    wdi_float_i = 0;
    repeat (4) @(negedge clk);
    low_supply_i = 1;
    repeat (8) @(negedge clk);
    low_supply_i = 0;
    wait_rn(1, 2000, n);
    chk_rng("R7", "ext reset width", n, (E_RST / DIV) * ETP + 3, ETOL);
    wait_rn(0, 4000, n);
    chk_rng("R7", "ext long period", n, (E_LONG / DIV) * ETP, ETOL);
    wait_rn(1, 2000, n);
    repeat (8) @(negedge clk);
    wdi_i = ~wdi_i;
    wait_rn(0, 4000, n);
    chk_rng("R7", "ext normal period", n, (E_NORM / DIV) * ETP + 3, ETOL);
  endtask

  initial begin
    t_reset_state();
    t_powerup();
    t_float();
    t_periodic();
    t_handover();
    t_osc_hi();
    t_supply();
    t_ext();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): actual=hung expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule